// File: doc/BRIEF.md
# ADC Scan Sequencer with Limit and Zero-Crossing Checks

This block steps a front end built from two sample-and-hold paths and two 12-bit converters through a programmed list of up to eight channel numbers. For each list slot it drives a multiplexer select and a one-cycle start strobe to one converter. It then waits for that converter's done pulse and stores the returned sample in a result buffer indexed by the slot. The converters run either one at a time (sequential pairing) or as a pair sampled at the same instant (simultaneous pairing).

A scan can run once per rising edge of `run`, once per `trig` pulse, or back to back while `run` stays high. Every stored sample is checked against a shared low/high window and against a zero-crossing offset, with a per-slot direction select. Sticky flags record out-of-window samples, crossings, the end of a scan and pairing errors. Each flag is cleared by a one-cycle clear pulse. Three interrupt outputs gate the flags with their enables.

Top module: `adc_scan_seq`

## Requirements
- R1: Scan modes are selected by `mode`: 0 = once, 1 = triggered, 2 = continuous (3 acts as once). In once mode a rising edge of `run` starts exactly one scan, and holding `run` high starts no further scan. In continuous mode scans follow each other while `run` is high. Clearing `run` lets the current scan finish and starts no new one.
- R2: In triggered mode, with `run` high, a `trig` pulse seen while idle starts one scan. A `trig` pulse seen while `busy` is high is ignored. Without a trigger no scan starts.
- R3: In sequential pairing (`simul`=0), slot k for k <= `len_m1` converts channel `list_cfg[3k+2:3k]`. Even slots use converter A and odd slots use converter B, and the two never start together. The sample is stored in buffer slot k. Slots above `len_m1` keep their values.
- R4: In simultaneous pairing (`simul`=1), pair p covers slot p on converter A and slot p+4 on converter B. Both start strobes rise in the same cycle. The pairs used are 0 to min(`len_m1`,3), and each start strobe lasts one cycle.
- R5: A simultaneous pair whose two slots name the same channel sets `err_flag`. That pair starts no conversion and its two buffer slots stay unchanged.
- R6: A stored sample below `lo_limit` or above `hi_limit` sets `lim_flags[k]` for its slot k.
- R7: A sample counts as "above" when it is >= `zc_offset`. `zc_sel[2k+1:2k]` selects the crossing directions for slot k: 0 = none, 1 = below-to-above, 2 = above-to-below, 3 = either. A matching change from the previous sample stored in that slot sets `zc_flags[k]`. The first sample a slot stores after reset sets no crossing flag.
- R8: `eos_flag` is set when the last slot or pair of a scan completes, and `busy` then falls.
- R9: A one-cycle pulse on `clr_eos`, `clr_err`, `clr_lim[k]` or `clr_zc[k]` clears the matching flag or bit and leaves the others untouched.
- R10: `irq_eos` = `eos_flag` AND `en_eos`. `irq_lim` = (any `lim_flags` bit) AND `en_lim`. `irq_zc` = (any `zc_flags` bit) AND `en_zc`.
- R11: After reset the block is idle, all flags are zero, all buffer slots read zero and both start strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Scan mode: 0 once, 1 triggered, 2 continuous |
| simul | input | 1 | 1 = simultaneous pairing, 0 = sequential |
| run | input | 1 | Run enable |
| trig | input | 1 | Scan trigger pulse (triggered mode) |
| list_cfg | input | 24 | Channel list, 3 bits per slot, slot k at bits 3k+2:3k |
| len_m1 | input | 3 | Number of slots used minus one |
| lo_limit | input | 12 | Low window limit |
| hi_limit | input | 12 | High window limit |
| zc_offset | input | 12 | Zero-crossing reference |
| zc_sel | input | 16 | Crossing direction per slot, 2 bits each |
| en_eos | input | 1 | End-of-scan interrupt enable |
| en_lim | input | 1 | Limit interrupt enable |
| en_zc | input | 1 | Zero-crossing interrupt enable |
| clr_eos | input | 1 | Clear end-of-scan flag |
| clr_err | input | 1 | Clear pairing error flag |
| clr_lim | input | 8 | Clear limit flag per slot |
| clr_zc | input | 8 | Clear crossing flag per slot |
| mux_a | output | 3 | Channel select, converter A |
| mux_b | output | 3 | Channel select, converter B |
| start_a | output | 1 | Start strobe, converter A |
| start_b | output | 1 | Start strobe, converter B |
| done_a | input | 1 | Conversion done, converter A |
| done_b | input | 1 | Conversion done, converter B |
| res_a | input | 12 | Result, converter A |
| res_b | input | 12 | Result, converter B |
| busy | output | 1 | Scan in progress |
| rd_slot | input | 3 | Result buffer read index |
| rd_data | output | 12 | Result buffer read data |
| lim_flags | output | 8 | Out-of-window flags per slot |
| zc_flags | output | 8 | Zero-crossing flags per slot |
| eos_flag | output | 1 | End-of-scan flag |
| err_flag | output | 1 | Pairing error flag |
| irq_eos | output | 1 | End-of-scan interrupt |
| irq_lim | output | 1 | Limit interrupt |
| irq_zc | output | 1 | Zero-crossing interrupt |

## Verification
The bench builds the block with its defaults: eight channels, eight slots and 12-bit samples. With these values it can sweep every list length from one to eight in both pairings, and it can compare each slot's buffer entry and start counts per converter against a model that tracks the history of each slot. The same small configuration makes it possible to try all four crossing-direction codes, including a sample equal to the offset, as well as a clashing pair and the edges of the limit window.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    SCAN_ONCE = 2'd0,
    SCAN_TRIG = 2'd1,
    SCAN_CONT = 2'd2
  } scan_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  // Window test: strictly below low or strictly above high.
  function automatic logic out_of_window(input int unsigned v,
                                         input int unsigned lo,
                                         input int unsigned hi);
    return (v < lo) || (v > hi);
  endfunction

  // Crossing test: sel[0] below-to-above, sel[1] above-to-below.
  function automatic logic crossing_hit(input logic seen, input logic was_above,
                                        input logic now_above, input logic [1:0] sel);
    return seen && ((sel[0] && !was_above && now_above) ||
                    (sel[1] && was_above && !now_above));
  endfunction

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int NSLOT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode,
  input  logic                     simul,
  input  logic                     run,
  input  logic                     trig,
  input  logic [NSLOT*$clog2(NCH)-1:0] list_cfg,
  input  logic [$clog2(NSLOT)-1:0] len_m1,
  input  logic                     done_a,
  input  logic                     done_b,
  output logic [$clog2(NCH)-1:0]   mux_a,
  output logic [$clog2(NCH)-1:0]   mux_b,
  output logic                     start_a,
  output logic                     start_b,
  output logic                     busy,
  output logic                     acc_a,
  output logic                     acc_b,
  output logic [$clog2(NSLOT)-1:0] slot_a,
  output logic [$clog2(NSLOT)-1:0] slot_b,
  output logic                     clash,
  output logic                     eos_set
);
  localparam int CW   = $clog2(NCH);
  localparam int SW   = $clog2(NSLOT);
  localparam int HALF = NSLOT / 2;

  seq_state_e     st;
  logic [SW-1:0]  idx;
  logic [SW-1:0]  last_idx;
  logic           got_a, got_b, run_q;
  logic           need_a, need_b, fin_a, fin_b, complete, step, launch;

  assign slot_a = simul ? {1'b0, idx[SW-2:0]} : idx;
  assign slot_b = simul ? {1'b1, idx[SW-2:0]} : idx;
  assign mux_a  = list_cfg[slot_a*CW +: CW];
  assign mux_b  = list_cfg[slot_b*CW +: CW];

  assign need_a = simul || !idx[0];
  assign need_b = simul || idx[0];
  assign clash  = (st == ST_ISSUE) && simul && (mux_a == mux_b);

  assign start_a = (st == ST_ISSUE) && need_a && !clash;
  assign start_b = (st == ST_ISSUE) && need_b && !clash;

  assign acc_a = (st == ST_WAIT) && need_a && !got_a && done_a;
  assign acc_b = (st == ST_WAIT) && need_b && !got_b && done_b;
  assign fin_a = !need_a || got_a || acc_a;
  assign fin_b = !need_b || got_b || acc_b;
  assign complete = (st == ST_WAIT) && fin_a && fin_b;
  assign step     = clash || complete;

  assign last_idx = (simul && (len_m1 > SW'(HALF - 1))) ? SW'(HALF - 1) : len_m1;
  assign eos_set  = step && (idx == last_idx);
  assign busy     = (st != ST_IDLE);

  always_comb begin
    launch = 1'b0;
    if (st == ST_IDLE && run) begin
      case (scan_mode_e'(mode))
        SCAN_TRIG: launch = trig;
        SCAN_CONT: launch = 1'b1;
        default:   launch = !run_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      idx   <= '0;
      got_a <= 1'b0;
      got_b <= 1'b0;
      run_q <= 1'b0;
    end else begin
      run_q <= run;
      case (st)
        ST_IDLE: if (launch) begin
          idx <= '0;
          st  <= ST_ISSUE;
        end
        ST_ISSUE: if (!clash) begin
          got_a <= 1'b0;
          got_b <= 1'b0;
          st    <= ST_WAIT;
        end
        default: begin
          if (acc_a) got_a <= 1'b1;
          if (acc_b) got_b <= 1'b1;
        end
      endcase
      if (step) begin
        if (eos_set) st <= ST_IDLE;
        else begin
          idx <= idx + 1'b1;
          st  <= ST_ISSUE;
        end
      end
    end
  end
endmodule

// File: rtl/adc_slot_unit.sv
module adc_slot_unit
  import adc_scan_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] offset,
  input  logic [1:0]   sel,
  input  logic         clr_lim,
  input  logic         clr_zc,
  output logic [W-1:0] value,
  output logic         lim_flag,
  output logic         zc_flag
);
  logic seen, above, now_above, lim_hit, zc_hit;

  assign now_above = (wdata >= offset);
  assign lim_hit   = wr && out_of_window(32'(wdata), 32'(lo), 32'(hi));
  assign zc_hit    = wr && crossing_hit(seen, above, now_above, sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value    <= '0;
      seen     <= 1'b0;
      above    <= 1'b0;
      lim_flag <= 1'b0;
      zc_flag  <= 1'b0;
    end else begin
      if (wr) begin
        value <= wdata;
        seen  <= 1'b1;
        above <= now_above;
      end
      lim_flag <= lim_hit || (lim_flag && !clr_lim);
      zc_flag  <= zc_hit  || (zc_flag  && !clr_zc);
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH   = 8,
  parameter int NSLOT = 8,
  parameter int W     = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [1:0]                    mode,
  input  logic                          simul,
  input  logic                          run,
  input  logic                          trig,
  input  logic [NSLOT*$clog2(NCH)-1:0]  list_cfg,
  input  logic [$clog2(NSLOT)-1:0]      len_m1,
  input  logic [W-1:0]                  lo_limit,
  input  logic [W-1:0]                  hi_limit,
  input  logic [W-1:0]                  zc_offset,
  input  logic [2*NSLOT-1:0]            zc_sel,
  input  logic                          en_eos,
  input  logic                          en_lim,
  input  logic                          en_zc,
  input  logic                          clr_eos,
  input  logic                          clr_err,
  input  logic [NSLOT-1:0]              clr_lim,
  input  logic [NSLOT-1:0]              clr_zc,
  output logic [$clog2(NCH)-1:0]        mux_a,
  output logic [$clog2(NCH)-1:0]        mux_b,
  output logic                          start_a,
  output logic                          start_b,
  input  logic                          done_a,
  input  logic                          done_b,
  input  logic [W-1:0]                  res_a,
  input  logic [W-1:0]                  res_b,
  output logic                          busy,
  input  logic [$clog2(NSLOT)-1:0]      rd_slot,
  output logic [W-1:0]                  rd_data,
  output logic [NSLOT-1:0]              lim_flags,
  output logic [NSLOT-1:0]              zc_flags,
  output logic                          eos_flag,
  output logic                          err_flag,
  output logic                          irq_eos,
  output logic                          irq_lim,
  output logic                          irq_zc
);
  localparam int CW = $clog2(NCH);
  localparam int SW = $clog2(NSLOT);

  // Internal events, named for the checker.
  logic          acc_a, acc_b, clash, eos_set;
  logic [SW-1:0] slot_a, slot_b;
  logic [W-1:0]  vals [NSLOT];

  adc_seq_ctrl #(.NCH(NCH), .NSLOT(NSLOT)) u_ctrl (
    .clk, .rst_n, .mode, .simul, .run, .trig, .list_cfg, .len_m1,
    .done_a, .done_b, .mux_a, .mux_b, .start_a, .start_b, .busy,
    .acc_a, .acc_b, .slot_a, .slot_b, .clash, .eos_set
  );

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    logic hit_a, hit_b;
    assign hit_a = acc_a && (slot_a == SW'(k));
    assign hit_b = acc_b && (slot_b == SW'(k));
    adc_slot_unit #(.W(W)) u_slot (
      .clk, .rst_n,
      .wr      (hit_a || hit_b),
      .wdata   (hit_a ? res_a : res_b),
      .lo      (lo_limit),
      .hi      (hi_limit),
      .offset  (zc_offset),
      .sel     (zc_sel[2*k +: 2]),
      .clr_lim (clr_lim[k]),
      .clr_zc  (clr_zc[k]),
      .value   (vals[k]),
      .lim_flag(lim_flags[k]),
      .zc_flag (zc_flags[k])
    );
  end

  assign rd_data = vals[rd_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eos_flag <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      eos_flag <= eos_set || (eos_flag && !clr_eos);
      err_flag <= clash   || (err_flag && !clr_err);
    end
  end

  assign irq_eos = eos_flag && en_eos;
  assign irq_lim = (|lim_flags) && en_lim;
  assign irq_zc  = (|zc_flags) && en_zc;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          simul,
  input logic          start_a,
  input logic          start_b,
  input logic [CW-1:0] mux_a,
  input logic [CW-1:0] mux_b,
  input logic          busy,
  input logic          clash,
  input logic          acc_a,
  input logic          acc_b,
  input logic          eos_flag
);
  p_seq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !simul |-> !(start_a && start_b));

  p_acc_in_scan_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_a || acc_b) |-> busy);

  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_a || start_b) |=> !(start_a || start_b));

  p_sel_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_a |=> $stable(mux_a));

  p_pair_distinct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_a && start_b) |-> (mux_a != mux_b));

  p_clash_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> !(start_a || start_b));

  p_eos_after_scan_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eos_flag) |-> $past(busy));
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CW(CW)) u_chk (.*);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8, NSLOT = 8, W = 12, CW = 3, SW = 3, LAT = 3;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic simul = 0, run = 0, trig = 0;
  logic [NSLOT*CW-1:0] list_cfg;
  logic [SW-1:0] len_m1 = 0;
  logic [W-1:0] lo_limit = 0, hi_limit = 4095, zc_offset = 2000;
  logic [2*NSLOT-1:0] zc_sel;
  logic en_eos = 0, en_lim = 0, en_zc = 0, clr_eos = 0, clr_err = 0;
  logic [NSLOT-1:0] clr_lim = 0, clr_zc = 0;
  logic [CW-1:0] mux_a, mux_b;
  logic start_a, start_b, done_a = 0, done_b = 0, busy;
  logic [W-1:0] res_a = 0, res_b = 0, rd_data;
  logic [SW-1:0] rd_slot = 0;
  logic [NSLOT-1:0] lim_flags, zc_flags;
  logic eos_flag, err_flag, irq_eos, irq_lim, irq_zc;

  logic [CW-1:0] lst [NSLOT];
  logic [1:0]    selv [NSLOT];
  int            ain [NCH];
  int exp_val [NSLOT];
  logic [NSLOT-1:0] exp_lim = 0, exp_zc = 0;
  logic mseen [NSLOT], mabove [NSLOT];
  logic exp_err = 0;
  int checks = 0, fails = 0;
  int n_a = 0, n_b = 0, cnt_a = 0, cnt_b = 0, ch_a = 0, ch_b = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @* begin
    for (int k = 0; k < NSLOT; k++) begin
      list_cfg[k*CW +: CW] = lst[k];
      zc_sel[2*k +: 2] = selv[k];
    end
  end

  adc_scan_seq i_adc_scan_seq (.*);

  // Fixed-latency converter model, driven away from the active edge.
  always @(negedge clk) begin
    done_a = 0; done_b = 0;
    if (cnt_a == 1) begin done_a = 1; res_a = W'(ain[ch_a]); end
    if (cnt_b == 1) begin done_b = 1; res_b = W'(ain[ch_b]); end
    if (cnt_a != 0) cnt_a--;
    if (cnt_b != 0) cnt_b--;
    if (start_a) begin cnt_a = LAT; ch_a = mux_a; n_a++; end
    if (start_b) begin cnt_b = LAT; ch_b = mux_b; n_b++; end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  // Model of one stored sample.
  task automatic put(input int k, input int ch);
    int v; logic now;
    v = ain[ch];
    exp_val[k] = v;
    if (v < int'(lo_limit) || v > int'(hi_limit)) exp_lim[k] = 1;
    now = (v >= int'(zc_offset));
    if (mseen[k] && ((selv[k][0] && !mabove[k] && now) || (selv[k][1] && mabove[k] && !now)))
      exp_zc[k] = 1;
    mseen[k] = 1; mabove[k] = now;
  endtask

  task automatic model_scan();
    int len;
    len = int'(len_m1) + 1;
    if (!simul) begin
      for (int k = 0; k < len; k++) put(k, lst[k]);
    end else begin
      for (int p = 0; p < (len > 4 ? 4 : len); p++) begin
        if (lst[p] == lst[p+4]) exp_err = 1;
        else begin put(p, lst[p]); put(p+4, lst[p+4]); end
      end
    end
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr_eos = 1; clr_err = 1; clr_lim = '1; clr_zc = '1;
    @(negedge clk);
    clr_eos = 0; clr_err = 0; clr_lim = 0; clr_zc = 0;
    exp_lim = 0; exp_zc = 0; exp_err = 0;
  endtask

  task automatic wait_scan();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  // Once mode: one scan on the run edge, none while run stays high (R1).
  task automatic run_once(input string tag);
    int a0, b0;
    @(negedge clk); mode = 0; run = 1;
    @(negedge clk);
    wait_scan();
    model_scan();
    a0 = n_a + n_b;
    repeat (20) @(negedge clk);
    chk({tag, " R1 once no restart"}, n_a + n_b, a0);
    run = 0;
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < NSLOT; k++) begin
      @(negedge clk); rd_slot = SW'(k); #1;
      chk({tag, " buffer"}, int'(rd_data), exp_val[k]);
    end
    chk({tag, " R6 lim"}, int'(lim_flags), int'(exp_lim));
    chk({tag, " R7 zc"}, int'(zc_flags), int'(exp_zc));
    chk({tag, " R5 err"}, int'(err_flag), int'(exp_err));
  endtask

  initial begin
    int a0, b0, tot;
    for (int k = 0; k < NSLOT; k++) begin
      lst[k] = 0; selv[k] = 0; exp_val[k] = 0; mseen[k] = 0; mabove[k] = 0;
    end
    for (int c = 0; c < NCH; c++) ain[c] = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", int'(busy), 0);
    chk("R11 start", int'(start_a | start_b), 0);
    chk("R11 flags", int'({lim_flags, zc_flags, eos_flag, err_flag}), 0);
    chk("R11 buffer", int'(rd_data), 0);
    rst_n = 1;
    @(negedge clk);

    // R3 sequential sweep over all lengths, repeated channel in slot 7
    for (int len = 1; len <= 8; len++) begin
      for (int k = 0; k < NSLOT; k++) lst[k] = CW'((k*3 + len) % 8);
      lst[7] = lst[0];
      for (int c = 0; c < NCH; c++) ain[c] = c*411 + len*13;
      simul = 0; len_m1 = SW'(len - 1);
      clear_all();
      a0 = n_a; b0 = n_b;
      run_once("R3 seq");
      chk("R3 starts A", n_a - a0, (len + 1) / 2);
      chk("R3 starts B", n_b - b0, len / 2);
      chk("R8 eos", int'(eos_flag), 1);
      check_all("R3 seq");
    end

    // R10 / R9 on the end-of-scan flag
    @(negedge clk); en_eos = 1; #1;
    chk("R10 irq_eos on", int'(irq_eos), 1);
    en_eos = 0; #1;
    chk("R10 irq_eos gated", int'(irq_eos), 0);
    @(negedge clk); clr_eos = 1; @(negedge clk); clr_eos = 0;
    chk("R9 eos cleared", int'(eos_flag), 0);

    // R4 simultaneous sweep
    for (int len = 1; len <= 8; len++) begin
      for (int k = 0; k < NSLOT; k++) lst[k] = CW'((k + len) % 8);
      for (int c = 0; c < NCH; c++) ain[c] = 3000 - c*277 - len*5;
      simul = 1; len_m1 = SW'(len - 1);
      clear_all();
      a0 = n_a; b0 = n_b;
      run_once("R4 simul");
      chk("R4 starts A", n_a - a0, len > 4 ? 4 : len);
      chk("R4 starts B", n_b - b0, len > 4 ? 4 : len);
      check_all("R4 simul");
    end

    // R5 clash on pair 1
    for (int k = 0; k < NSLOT; k++) lst[k] = CW'(k);
    lst[5] = lst[1];
    for (int c = 0; c < NCH; c++) ain[c] = 100 + c*50;
    simul = 1; len_m1 = 3;
    clear_all();
    a0 = n_a;
    run_once("R5 clash");
    chk("R5 skipped pair starts", n_a - a0, 3);
    check_all("R5 clash");
    @(negedge clk); clr_err = 1; @(negedge clk); clr_err = 0;
    chk("R9 err cleared", int'(err_flag), 0);

    // R6 limit window, edges included
    for (int k = 0; k < NSLOT; k++) lst[k] = CW'(k);
    ain[0] = 499; ain[1] = 500; ain[2] = 3000; ain[3] = 3001;
    ain[4] = 0;   ain[5] = 4095; ain[6] = 1700; ain[7] = 2999;
    lo_limit = 500; hi_limit = 3000; simul = 0; len_m1 = 7;
    clear_all();
    run_once("R6 lim");
    check_all("R6 lim");
    chk("R6 flags value", int'(lim_flags), 8'b0011_1001);
    @(negedge clk); en_lim = 1; #1;
    chk("R10 irq_lim", int'(irq_lim), 1);
    clr_lim = 8'b0000_1001; @(negedge clk); clr_lim = 0;
    chk("R9 lim partial clear", int'(lim_flags), 8'b0011_0000);
    en_lim = 0; lo_limit = 0; hi_limit = 4095;

    // R7 crossing sweep over all direction codes, equality counts as above
    for (int k = 0; k < NSLOT; k++) begin lst[k] = CW'(k); selv[k] = 2'(k % 4); end
    for (int s = 0; s < 5; s++) begin
      for (int c = 0; c < NCH; c++)
        ain[c] = (((s + c/4) % 2) == 1) ? ((s == 2) ? 2000 : 2600) : 1400;
      clear_all();
      run_once("R7 zc");
      check_all("R7 zc");
    end
    @(negedge clk); en_zc = 1; #1;
    chk("R10 irq_zc", int'(irq_zc), int'(|exp_zc));
    en_zc = 0;

    // R2 triggered mode
    clear_all();
    mode = 1; run = 1;
    a0 = n_a + n_b;
    repeat (20) @(negedge clk);
    chk("R2 no trigger no scan", n_a + n_b, a0);
    trig = 1; @(negedge clk); trig = 0;
    while (!busy) @(negedge clk);
    repeat (3) @(negedge clk);
    trig = 1; @(negedge clk); trig = 0;
    repeat (4) @(negedge clk);
    trig = 1; @(negedge clk); trig = 0;
    while (busy) @(negedge clk);
    model_scan();
    repeat (20) @(negedge clk);
    chk("R2 one scan only", n_a + n_b - a0, 8);
    chk("R2 idle after", int'(busy), 0);
    run = 0;
    check_all("R2 trig");

    // R1 continuous mode
    @(negedge clk);
    mode = 2; a0 = n_a + n_b; run = 1;
    repeat (150) @(negedge clk);
    run = 0;
    while (busy) @(negedge clk);
    tot = n_a + n_b - a0;
    for (int s = 0; s < tot / 8; s++) model_scan();
    chk("R1 whole scans", tot % 8, 0);
    chk("R1 repeated", int'(tot >= 16), 1);
    repeat (20) @(negedge clk);
    chk("R1 stops after run cleared", n_a + n_b - a0, tot);
    check_all("R1 cont");

    summary();
    $finish;
  end
endmodule